// File: doc/BRIEF.md
# H-Bridge Gate Controller with Chopping Current Limit

This block is the digital part of a full-bridge motor driver. Two polarity inputs pick, for each half-bridge (leg A and leg B), whether the upper or the lower switch conducts. An enable input and two disable inputs of opposite sense can tri-state the whole bridge. Four gate commands come out, two per leg. A leg is tri-stated when both of its commands are low.

Load current is limited by chopping with a fixed off time. A current-limit comparator flag seen outside the blanking window turns every switch off for a fixed interval, and drive then resumes. Each time the bridge turns on from fully off, a blanking window opens in which the current-limit flag is ignored. The short-circuit flag acts at all times. Short circuit and over-temperature each set a latch that holds the bridge off until the bridge is made inactive. Undervoltage turns the bridge off only while the flag is present. An active-low fault output reports all three conditions.

All comparator and control inputs are asynchronous, and each passes through a two-flop synchronizer. Timers count a tick that is TICK_DIV clocks long, and the tick divider restarts whenever a timer starts.

Top module: `hb_bridge_ctrl`

## Requirements
- R1: With the bridge active and no fault or chop in force, leg A drives `hs_a`=1,`ls_a`=0 when `pol_a`=1 and `hs_a`=0,`ls_a`=1 when `pol_a`=0; leg B does the same from `pol_b`. From a leg that is already off, a new input level shows at the gate outputs on the third rising clock edge after it is applied.
- R2: The upper and lower commands of one leg are never 1 together. When a leg changes sides, both of its commands stay 0 for exactly DEAD_CYCLES+1 clock cycles before the new side turns on.
- R3: `dis_hi`=1 turns off all four gate commands.
- R4: `dis_lo_n`=0 turns off all four gate commands.
- R5: `en`=0 (sleep) turns off all four gate commands.
- R6: When the synchronized current-limit flag is high, a leg is on, and the block is neither blanking nor already chopping, all commands are 0 from the next clock for OFF_TICKS*TICK_DIV+1 cycles. Drive then resumes.
- R7: The current-limit flag is ignored in the cycle in which the bridge first shows a gate on after being fully off, and for the following BLANK_TICKS*TICK_DIV cycles.
- R8: A short-circuit flag turns the bridge off and drives `fault_n` low on the same edge, during blanking as well. Both conditions hold after the flag clears.
- R9: An over-temperature flag turns the bridge off and drives `fault_n` low. Both conditions hold after the flag clears.
- R10: The short-circuit and over-temperature latches clear only in a cycle in which the synchronized controls make the bridge inactive (`en`=0, `dis_hi`=1 or `dis_lo_n`=0). Drive returns once the bridge is active again.
- R11: While `uv_flag` is high, all commands are 0 and `fault_n` is low. Nothing is latched, and drive returns on the third edge after the flag falls.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| pol_a | input | 1 | Polarity request for leg A |
| pol_b | input | 1 | Polarity request for leg B |
| en | input | 1 | Run (1) or sleep (0) |
| dis_hi | input | 1 | Disable, active high |
| dis_lo_n | input | 1 | Disable, active low |
| ilim_flag | input | 1 | Current-limit comparator flag |
| short_flag | input | 1 | Short-circuit comparator flag |
| otemp_flag | input | 1 | Over-temperature flag |
| uv_flag | input | 1 | Undervoltage flag |
| hs_a | output | 1 | Leg A upper switch on |
| ls_a | output | 1 | Leg A lower switch on |
| hs_b | output | 1 | Leg B upper switch on |
| ls_b | output | 1 | Leg B lower switch on |
| fault_n | output | 1 | Fault indication, active low |

## Verification
The assertions work on the synchronized flags. They assume each input holds its level for at least one clock, so that every change passes through the synchronizers and is seen. The bench changes inputs only on falling edges and holds every pulse for a whole clock. The dead-time property also assumes that OFF_TICKS*TICK_DIV exceeds DEAD_CYCLES, so that a chop never ends before a leg may turn on again. The bench configuration keeps to this.

// File: rtl/hb_pkg.sv
package hb_pkg;

  typedef enum logic [1:0] {
    LEG_OFF  = 2'd0,
    LEG_HIGH = 2'd1,
    LEG_LOW  = 2'd2
  } leg_cmd_t;

  // Wanted state of one leg, given permission to drive and its polarity.
  function automatic leg_cmd_t leg_request(input logic drive_ok, input logic pol);
    if (!drive_ok) return LEG_OFF;
    return pol ? LEG_HIGH : LEG_LOW;
  endfunction

  // True on the last clock of a tick period.
  function automatic logic tick_due(input int unsigned count, input int unsigned div);
    return (count + 1) >= div;
  endfunction

  // Fault latch update: clearing wins over setting.
  function automatic logic latch_next(input logic hold, input logic set, input logic clear);
    if (clear) return 1'b0;
    return hold | set;
  endfunction

endpackage

// File: rtl/hb_sync.sv
module hb_sync #(
  parameter int WIDTH = 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] d,
  output logic [WIDTH-1:0] q
);
  logic [WIDTH-1:0] stage1;
  logic [WIDTH-1:0] stage2;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stage1 <= '0;
      stage2 <= '0;
    end else begin
      stage1 <= d;
      stage2 <= stage1;
    end
  end

  assign q = stage2;
endmodule

// File: rtl/hb_leg.sv
module hb_leg
  import hb_pkg::*;
#(
  parameter int DEAD_CYCLES = 4
) (
  input  logic     clk,
  input  logic     rst_n,
  input  leg_cmd_t req,
  output logic     hs,
  output logic     ls
);
  localparam int DW = (DEAD_CYCLES > 0) ? $clog2(DEAD_CYCLES + 1) : 1;
  localparam logic [DW-1:0] GAP_FULL = DW'(DEAD_CYCLES);

  leg_cmd_t      cur;
  logic [DW-1:0] gap;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cur <= LEG_OFF;
      gap <= GAP_FULL;
    end else if (cur != LEG_OFF) begin
      if (req != cur) begin
        cur <= LEG_OFF;
        gap <= '0;
      end
    end else if (gap == GAP_FULL) begin
      if (req != LEG_OFF) cur <= req;
    end else begin
      gap <= gap + DW'(1);
    end
  end

  assign hs = (cur == LEG_HIGH);
  assign ls = (cur == LEG_LOW);
endmodule

// File: rtl/hb_regulator.sv
module hb_regulator
  import hb_pkg::*;
#(
  parameter int OFF_TICKS   = 41,
  parameter int BLANK_TICKS = 33,
  parameter int TICK_DIV    = 50
) (
  input  logic clk,
  input  logic rst_n,
  input  logic bridge_on,
  input  logic ilim_s,
  output logic chop_start,
  output logic off_active,
  output logic blanking
);
  localparam int TMAX = (OFF_TICKS > BLANK_TICKS) ? OFF_TICKS : BLANK_TICKS;
  localparam int TW   = $clog2(TMAX + 1);
  localparam int PW   = (TICK_DIV > 1) ? $clog2(TICK_DIV) : 1;

  logic          on_q;
  logic          turn_on;
  logic          tick;
  logic [PW-1:0] presc;
  logic [TW-1:0] blank_cnt;
  logic [TW-1:0] off_cnt;

  assign turn_on    = bridge_on & ~on_q;
  assign tick       = tick_due(32'(presc), TICK_DIV);
  assign blanking   = turn_on | (blank_cnt != '0);
  assign off_active = (off_cnt != '0);
  assign chop_start = ilim_s & bridge_on & ~blanking & ~off_active;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      on_q      <= 1'b0;
      presc     <= '0;
      blank_cnt <= '0;
      off_cnt   <= '0;
    end else begin
      on_q <= bridge_on;
      if (turn_on || chop_start || tick) presc <= '0;
      else                               presc <= presc + PW'(1);
      if (turn_on)                        blank_cnt <= TW'(BLANK_TICKS);
      else if (tick && blank_cnt != '0)   blank_cnt <= blank_cnt - TW'(1);
      if (chop_start)                     off_cnt <= TW'(OFF_TICKS);
      else if (tick && off_cnt != '0)     off_cnt <= off_cnt - TW'(1);
    end
  end
endmodule

// File: rtl/hb_bridge_ctrl.sv
module hb_bridge_ctrl
  import hb_pkg::*;
#(
  parameter int DEAD_CYCLES = 4,
  parameter int OFF_TICKS   = 41,
  parameter int BLANK_TICKS = 33,
  parameter int TICK_DIV    = 50
) (
  input  logic clk,
  input  logic rst_n,
  input  logic pol_a,
  input  logic pol_b,
  input  logic en,
  input  logic dis_hi,
  input  logic dis_lo_n,
  input  logic ilim_flag,
  input  logic short_flag,
  input  logic otemp_flag,
  input  logic uv_flag,
  output logic hs_a,
  output logic ls_a,
  output logic hs_b,
  output logic ls_b,
  output logic fault_n
);
  localparam int NLEG = 2;
  localparam int NSYNC = 9;

  logic [NSYNC-1:0] sync_q;
  logic [NLEG-1:0]  pol_s;
  logic en_s, dis_hi_s, dis_lo_n_s, ilim_s, short_s, ot_s, uv_s;

  hb_sync #(.WIDTH(NSYNC)) sync_i (
    .clk   (clk),
    .rst_n (rst_n),
    .d     ({pol_b, pol_a, en, dis_hi, dis_lo_n, ilim_flag, short_flag, otemp_flag, uv_flag}),
    .q     (sync_q)
  );

  assign pol_s      = sync_q[8:7];
  assign en_s       = sync_q[6];
  assign dis_hi_s   = sync_q[5];
  assign dis_lo_n_s = sync_q[4];
  assign ilim_s     = sync_q[3];
  assign short_s    = sync_q[2];
  assign ot_s       = sync_q[1];
  assign uv_s       = sync_q[0];

  // Bridge allowed to run by the control inputs
  logic active_w;
  assign active_w = en_s & ~dis_hi_s & dis_lo_n_s;

  logic sc_lat, ot_lat;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sc_lat <= 1'b0;
      ot_lat <= 1'b0;
    end else begin
      sc_lat <= latch_next(sc_lat, short_s, ~active_w);
      ot_lat <= latch_next(ot_lat, ot_s, ~active_w);
    end
  end

  logic chop_start, off_active, blanking, bridge_on;
  logic hold_off_w, drive_ok_w;
  assign hold_off_w = ~active_w | sc_lat | ot_lat | short_s | ot_s | uv_s
                    | off_active | chop_start;
  assign drive_ok_w = ~hold_off_w;

  leg_cmd_t        leg_req [NLEG];
  logic [NLEG-1:0] hs_v, ls_v;

  always_comb begin
    for (int g = 0; g < NLEG; g++) leg_req[g] = leg_request(drive_ok_w, pol_s[g]);
  end

  for (genvar g = 0; g < NLEG; g++) begin : g_leg
    hb_leg #(.DEAD_CYCLES(DEAD_CYCLES)) leg_i (
      .clk   (clk),
      .rst_n (rst_n),
      .req   (leg_req[g]),
      .hs    (hs_v[g]),
      .ls    (ls_v[g])
    );
  end

  assign bridge_on = |{hs_v, ls_v};

  hb_regulator #(
    .OFF_TICKS   (OFF_TICKS),
    .BLANK_TICKS (BLANK_TICKS),
    .TICK_DIV    (TICK_DIV)
  ) reg_i (
    .clk        (clk),
    .rst_n      (rst_n),
    .bridge_on  (bridge_on),
    .ilim_s     (ilim_s),
    .chop_start (chop_start),
    .off_active (off_active),
    .blanking   (blanking)
  );

  assign hs_a    = hs_v[0];
  assign ls_a    = ls_v[0];
  assign hs_b    = hs_v[1];
  assign ls_b    = ls_v[1];
  assign fault_n = ~(sc_lat | ot_lat | uv_s);
endmodule

// File: rtl/hb_bridge_chk.sv
module hb_bridge_chk #(
  parameter int DEAD_CYCLES = 4
) (
  input logic clk,
  input logic rst_n,
  input logic hs_a,
  input logic ls_a,
  input logic hs_b,
  input logic ls_b,
  input logic en_s,
  input logic dis_hi_s,
  input logic dis_lo_n_s,
  input logic short_s,
  input logic uv_s,
  input logic sc_lat,
  input logic ot_lat,
  input logic chop_start,
  input logic off_active
);
  localparam int RW = $clog2(DEAD_CYCLES + 2);
  localparam logic [RW-1:0] RUN_SAT = RW'(DEAD_CYCLES + 1);

  logic [RW-1:0] off_run_a, off_run_b;
  logic gates_any, run_ok;
  assign gates_any = hs_a | ls_a | hs_b | ls_b;
  assign run_ok    = en_s & ~dis_hi_s & dis_lo_n_s;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      off_run_a <= RUN_SAT;
      off_run_b <= RUN_SAT;
    end else begin
      if (hs_a || ls_a)             off_run_a <= '0;
      else if (off_run_a < RUN_SAT) off_run_a <= off_run_a + RW'(1);
      if (hs_b || ls_b)             off_run_b <= '0;
      else if (off_run_b < RUN_SAT) off_run_b <= off_run_b + RW'(1);
    end
  end

  // R2
  no_shoot_thru_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(hs_a && ls_a) && !(hs_b && ls_b));
  // R2
  dead_gap_a_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(hs_a) || $rose(ls_a)) |-> (off_run_a > RW'(DEAD_CYCLES)));
  // R2
  dead_gap_b_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(hs_b) || $rose(ls_b)) |-> (off_run_b > RW'(DEAD_CYCLES)));
  // R3
  dis_hi_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $past(dis_hi_s) |-> !gates_any);
  // R4
  dis_lo_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $past(!dis_lo_n_s) |-> !gates_any);
  // R5
  sleep_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $past(!en_s) |-> !gates_any);
  // R6
  chop_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (chop_start || off_active) |=> !gates_any);
  // R8
  short_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(short_s) || sc_lat) |-> !gates_any);
  // R9
  otemp_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ot_lat |-> !gates_any);
  // R10
  latch_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ((sc_lat || ot_lat) && run_ok) |=> (sc_lat || ot_lat));
  // R10
  latch_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($fell(sc_lat) || $fell(ot_lat)) |-> $past(!run_ok));
  // R11
  uv_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $past(uv_s) |-> !gates_any);
endmodule

bind hb_bridge_ctrl hb_bridge_chk #(.DEAD_CYCLES(DEAD_CYCLES)) chk_i (
  .clk        (clk),
  .rst_n      (rst_n),
  .hs_a       (hs_a),
  .ls_a       (ls_a),
  .hs_b       (hs_b),
  .ls_b       (ls_b),
  .en_s       (en_s),
  .dis_hi_s   (dis_hi_s),
  .dis_lo_n_s (dis_lo_n_s),
  .short_s    (short_s),
  .uv_s       (uv_s),
  .sc_lat     (sc_lat),
  .ot_lat     (ot_lat),
  .chop_start (chop_start),
  .off_active (off_active)
);

// File: tb/hb_bridge_ctrl_tb_top.sv
module hb_bridge_ctrl_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int DEAD  = 2;
  localparam int OFFT  = 3;
  localparam int BLANK = 4;
  localparam int DIV   = 2;
  localparam int LAT   = 3;               // sync + leg register
  localparam int CHOP_LEN  = OFFT * DIV;  // off-timer cycles
  localparam int BLANK_LEN = BLANK * DIV;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic pol_a = 0, pol_b = 0, en = 0, dis_hi = 0, dis_lo_n = 1;
  logic ilim_flag = 0, short_flag = 0, otemp_flag = 0, uv_flag = 0;
  logic hs_a, ls_a, hs_b, ls_b, fault_n;

  int checks = 0;
  int errors = 0;
  int shoot_seen = 0;
  bit done = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  hb_bridge_ctrl #(
    .DEAD_CYCLES (DEAD),
    .OFF_TICKS   (OFFT),
    .BLANK_TICKS (BLANK),
    .TICK_DIV    (DIV)
  ) dut_i (
    .clk(clk), .rst_n(rst_n), .pol_a(pol_a), .pol_b(pol_b), .en(en),
    .dis_hi(dis_hi), .dis_lo_n(dis_lo_n), .ilim_flag(ilim_flag),
    .short_flag(short_flag), .otemp_flag(otemp_flag), .uv_flag(uv_flag),
    .hs_a(hs_a), .ls_a(ls_a), .hs_b(hs_b), .ls_b(ls_b), .fault_n(fault_n)
  );

  function automatic logic [4:0] drive_exp(input logic pa, input logic pb);
    return {pa, ~pa, pb, ~pb, 1'b1};
  endfunction

  localparam logic [4:0] OFF_OK    = 5'b00001;
  localparam logic [4:0] OFF_FAULT = 5'b00000;

  task automatic step(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic check(input string tag, input logic [4:0] exp);
    logic [4:0] got;
    got = {hs_a, ls_a, hs_b, ls_b, fault_n};
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s: {hs_a,ls_a,hs_b,ls_b,fault_n} got %b expected %b at %0t",
               tag, got, exp, $time);
    end
  endtask

  // R2: shoot-through monitor at the ports
  always @(negedge clk) begin
    if (rst_n && ((hs_a && ls_a) || (hs_b && ls_b))) shoot_seen++;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: run did not complete, got hung expected finish");
      $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    step(3);
    check("R5 reset state", OFF_OK);
    rst_n = 1'b1;
    step(2);
    check("R5 sleep after reset", OFF_OK);

    // R1 and R5: latency of a turn-on from sleep
    pol_a = 1; pol_b = 0; en = 1;
    step(LAT - 1);
    check("R1 before latency", OFF_OK);
    step(1);
    check("R1 turn-on latency", drive_exp(1, 0));
    step(12);

    // R1: sweep of the polarity codes in a varied order
    for (int k = 0; k < 8; k++) begin
      logic [1:0] code;
      code = 2'((k * 3) % 4);
      pol_a = code[0]; pol_b = code[1];
      step(LAT + DEAD + 3);
      check("R1 polarity sweep", drive_exp(code[0], code[1]));
    end

    // R2: exact dead gap on leg A
    pol_a = 1; pol_b = 1;
    step(12);
    pol_a = 0;
    for (int s = 1; s <= 8; s++) begin
      step(1);
      if (s < LAT)                check("R2 before change", drive_exp(1, 1));
      else if (s < LAT + DEAD + 1) check("R2 dead gap", 5'b00101);
      else                        check("R2 new side", drive_exp(0, 1));
    end

    // R3, R4, R5: sweep of all control combinations
    pol_a = 1; pol_b = 0;
    for (int c = 0; c < 8; c++) begin
      logic [2:0] cc;
      cc = 3'(c);
      en = cc[0]; dis_hi = cc[1]; dis_lo_n = cc[2];
      step(LAT + DEAD + 4);
      if (cc[1])       check("R3 dis_hi sweep", OFF_OK);
      else if (!cc[2]) check("R4 dis_lo_n sweep", OFF_OK);
      else if (!cc[0]) check("R5 sleep sweep", OFF_OK);
      else             check("R1 active sweep", drive_exp(1, 0));
    end
    en = 1; dis_hi = 0; dis_lo_n = 1;
    step(12);
    dis_hi = 1;
    step(LAT - 1);
    check("R3 before latency", drive_exp(1, 0));
    step(1);
    check("R3 disable edge", OFF_OK);
    dis_hi = 0;
    step(20);

    // R6: single-cycle current-limit pulse outside blanking
    ilim_flag = 1;
    step(1);
    ilim_flag = 0;
    for (int s = 2; s <= LAT + CHOP_LEN + 1; s++) begin
      step(1);
      if (s < LAT)                 check("R6 before chop", drive_exp(1, 0));
      else if (s <= LAT + CHOP_LEN) check("R6 off time", OFF_OK);
      else                         check("R6 resume", drive_exp(1, 0));
    end
    step(20);

    // R7: flag held high across a turn-on from sleep
    en = 0;
    step(8);
    ilim_flag = 1;
    step(4);
    en = 1;
    for (int s = 1; s <= LAT + BLANK_LEN + 2; s++) begin
      step(1);
      if (s < LAT)                      check("R7 still asleep", OFF_OK);
      else if (s <= LAT + BLANK_LEN + 1) check("R7 blanked", drive_exp(1, 0));
      else                              check("R7 chop after blank", OFF_OK);
    end
    ilim_flag = 0;
    step(25);
    check("R6 drive after chop", drive_exp(1, 0));

    // R8: short during steady drive, then R10 clear by a disable pulse
    short_flag = 1;
    step(LAT - 1);
    check("R8 before latency", drive_exp(1, 0));
    step(1);
    check("R8 short shutdown", OFF_FAULT);
    short_flag = 0;
    step(10);
    check("R8 latched after flag clears", OFF_FAULT);
    pol_a = 0;
    step(10);
    check("R10 polarity does not clear", OFF_FAULT);
    dis_hi = 1;
    step(1);
    dis_hi = 0;
    step(10);
    check("R10 cleared by dis_hi pulse", drive_exp(0, 0));

    // R8: short during blanking, R10 clear by sleep pulse
    en = 0;
    step(8);
    en = 1;
    step(LAT + 1);
    short_flag = 1;
    step(1);
    short_flag = 0;
    step(LAT - 1);
    check("R8 short in blanking", OFF_FAULT);
    step(10);
    check("R8 blanking short latched", OFF_FAULT);
    en = 0;
    step(1);
    en = 1;
    step(10);
    check("R10 cleared by en cycle", drive_exp(0, 0));

    // R9: over-temperature, R10 clear by dis_lo_n pulse
    otemp_flag = 1;
    step(LAT);
    check("R9 overtemp shutdown", OFF_FAULT);
    otemp_flag = 0;
    step(10);
    check("R9 latched after flag clears", OFF_FAULT);
    dis_lo_n = 0;
    step(1);
    dis_lo_n = 1;
    step(10);
    check("R10 cleared by dis_lo_n pulse", drive_exp(0, 0));

    // R11: undervoltage, non-latching
    uv_flag = 1;
    step(LAT - 1);
    check("R11 fault before outputs", {drive_exp(0, 0)} & 5'b11110);
    step(1);
    check("R11 undervoltage off", OFF_FAULT);
    step(6);
    uv_flag = 0;
    step(LAT - 1);
    check("R11 fault released", OFF_OK);
    step(1);
    check("R11 drive released", drive_exp(0, 0));

    // R2: no shoot-through seen over the whole run
    checks++;
    if (shoot_seen != 0) begin
      errors++;
      $display("FAIL R2 shoot-through monitor: got %0d events expected 0", shoot_seen);
    end

    done = 1;
    $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule